// File: doc/BRIEF.md
# Overcurrent Fault Response Controller

This block decides how a three-phase half-bridge gate driver reacts when an overcurrent is detected. Each phase brings two overcurrent flags: one from a drain-source voltage monitor and one from a sense-resistor monitor. An 11-bit control word selects the reaction. The overcurrent can latch the bridges off until software clears it. It can shut them off for a fixed time and then re-enable them. It can only raise a status flag, or it can be ignored. The control word also selects whether the reaction covers all three half-bridges or only the phase that fired. It selects which of two retry durations applies. A threshold code in the word can switch off the drain-source input completely.

The reaction is run by a three-state machine. ST_RUN is normal operation. ST_LATCHED holds a latched fault. ST_RETRY holds a timed fault. The transitions are:
- RUN→LATCHED: an event arrives while mode 00 is set.
- RUN→RETRY: an event arrives while mode 01 is set. This also loads the retry timer.
- LATCHED→RUN: a clear pulse arrives while no flag is asserted.
- RETRY→RETRY: a new event arrives during the retry. It reloads the timer and adds phases to the shutdown mask.
- RETRY→RUN: the timer expires with no event present.

In modes 10 and 11 the machine stays in RUN. The dead-time code is passed through to the gate timing logic.

Top module: `ocp_response_ctrl`

## Requirements
- R1: After reset the control word reads 0x145. Its fields are: bit10 retry select=0, bits9:8 dead time=01, bits7:6 mode=01, bit5 scope=0, bits4:3 reserved=00, bits2:0 threshold=101. After reset all bridge enables are 1, and the status and latched outputs are 0.
- R2: A write stores all 11 bits, including the reserved bits 4:3. The value reads back from the next cycle on. The reserved bits have no effect on the reaction.
- R3: Mode 00 applies on the clock edge where an event is sampled. From that edge the affected bridges are disabled, and status and latched read 1. They stay that way until a clear-fault pulse is sampled while no active overcurrent flag is asserted. A clear pulse given while a flag is still asserted is ignored.
- R4: Mode 01 applies on the event edge. From that edge the affected bridges are disabled for exactly N clock cycles and then re-enable by themselves. N is 4 ms of clock when bit10=0 and 50 µs of clock when bit10=1. In the shortened test build N is 40 and 8.
- R5: An event that arrives during a retry restarts the full retry time from that edge. Its phases are added to the disabled set.
- R6: Mode 10 raises status one cycle after an event is sampled. It keeps all bridges enabled and latched low.
- R7: Mode 11 gives no status, no shutdown and no latch for any event.
- R8: With bit5=0 any event disables all three bridges. With bit5=1 only the phases whose flags fired are disabled.
- R9: With threshold code 111 the drain-source flags are ignored. The sense-resistor flags still act.
- R10: A mode change written while a fault is held does not alter that fault. The new mode applies to the next event detected in normal operation.
- R11: The dead-time output equals control bits 9:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wdata | input | 11 | Control word write data |
| cfg_rdata | output | 11 | Control word read data |
| vds_oc | input | 3 | Per-phase drain-source overcurrent flags |
| sen_oc | input | 3 | Per-phase sense-resistor overcurrent flags |
| clr_fault | input | 1 | Clear-fault pulse for the latched mode |
| bridge_en | output | 3 | Per-phase half-bridge enable (1 = may switch) |
| oc_status | output | 1 | Overcurrent fault or report flag |
| fault_latched | output | 1 | A latched fault is held |
| dt_code | output | 2 | Dead-time selection for the gate timing logic |

## Verification
The hardest situation to reach from the ports is a second event that lands in the middle of a running retry, on a different phase. It must reload the timer and widen the disabled set at the same time. The stimulus enables per-phase scope and starts a short retry from one phase. After a counted number of edges it raises a flag on another phase. It then samples the enables at the last cycle before the expected re-enable and at the re-enable cycle itself. A clear pulse given while a flag is still held, and a mode rewrite during a latched fault, are reached the same way: the flag or the write is held across a known edge and the outputs are sampled after it.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [1:0] {
        RESP_LATCH  = 2'b00,
        RESP_RETRY  = 2'b01,
        RESP_REPORT = 2'b10,
        RESP_IGNORE = 2'b11
    } resp_mode_e;

    typedef enum logic [1:0] {
        ST_RUN     = 2'b00,
        ST_LATCHED = 2'b01,
        ST_RETRY   = 2'b10
    } fault_st_e;

    // Field order is decoded by the response logic; keep it packed as is.
    typedef struct packed {
        logic       fast_retry;
        logic [1:0] dt_sel;
        resp_mode_e mode;
        logic       per_phase;
        logic [1:0] spare;
        logic [2:0] vds_thr;
    } ocp_cfg_t;

    localparam int          CFG_W    = $bits(ocp_cfg_t);
    localparam logic [10:0] CFG_INIT = 11'h145;
    localparam logic [2:0]  VDS_OFF  = 3'b111;

endpackage

// File: rtl/ocp_cfg_reg.sv
module ocp_cfg_reg #(
    parameter int          W     = 11,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= INIT;
        end else if (wr_en) begin
            q <= wdata;
        end
    end

    // R2: a write is visible on the next cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == $past(wdata)));

endmodule

// File: rtl/ocp_event_merge.sv
module ocp_event_merge #(
    parameter int NPH = 3
) (
    input  logic [NPH-1:0] vds_oc,
    input  logic [NPH-1:0] sen_oc,
    input  logic [2:0]     vds_thr,
    output logic [NPH-1:0] evt
);
    import ocp_pkg::*;

    logic vds_live;
    assign vds_live = (vds_thr != VDS_OFF);

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        assign evt[p] = sen_oc[p] | (vds_oc[p] & vds_live);
    end

endmodule

// File: rtl/ocp_retry_timer.sv
module ocp_retry_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - CW'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign expired = (cnt_q == '0);

    // R5: every load restarts the full window
    a_r5_reload_full: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val) - CW'(1)));

    // R4: the window shrinks by one each idle cycle
    a_r4_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/ocp_fault_fsm.sv
module ocp_fault_fsm #(
    parameter int NPH = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPH-1:0]     evt,
    input  ocp_pkg::resp_mode_e mode,
    input  logic               per_phase,
    input  logic               clr_fault,
    input  logic               tmr_expired,
    output logic               tmr_load,
    output logic [NPH-1:0]     bridge_en,
    output logic               oc_status,
    output logic               fault_latched
);
    import ocp_pkg::*;

    fault_st_e      state_q, state_d;
    logic [NPH-1:0] mask_q, mask_d;
    logic           report_q, report_d;
    logic           hit;
    logic [NPH-1:0] sel;

    assign hit = |evt;
    assign sel = per_phase ? evt : {NPH{1'b1}};

    always_comb begin
        state_d  = state_q;
        mask_d   = mask_q;
        report_d = 1'b0;
        tmr_load = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (hit) begin
                    unique case (mode)
                        RESP_LATCH: begin
                            state_d = ST_LATCHED;
                            mask_d  = sel;
                        end
                        RESP_RETRY: begin
                            state_d  = ST_RETRY;
                            mask_d   = sel;
                            tmr_load = 1'b1;
                        end
                        RESP_REPORT: report_d = 1'b1;
                        RESP_IGNORE: report_d = 1'b0;
                    endcase
                end
            end
            ST_LATCHED: begin
                if (hit) begin
                    mask_d = mask_q | sel;
                end else if (clr_fault) begin
                    state_d = ST_RUN;
                    mask_d  = '0;
                end
            end
            ST_RETRY: begin
                if (hit) begin
                    mask_d   = mask_q | sel;
                    tmr_load = 1'b1;
                end else if (tmr_expired) begin
                    state_d = ST_RUN;
                    mask_d  = '0;
                end
            end
            default: begin
                state_d = ST_RUN;
                mask_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_RUN;
            mask_q   <= '0;
            report_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            mask_q   <= mask_d;
            report_q <= report_d;
        end
    end

    always_comb begin
        bridge_en     = (state_q == ST_RUN) ? {NPH{1'b1}} : ~mask_q;
        oc_status     = (state_q != ST_RUN) | report_q;
        fault_latched = (state_q == ST_LATCHED);
    end

    // R3: a held fault survives without a clean clear
    a_r3_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCHED && (!clr_fault || hit)) |=> (state_q == ST_LATCHED));

    // R4: retry cannot end while the timer still runs
    a_r4_no_early_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RETRY && !tmr_expired) |=> (state_q != ST_RUN));

    // R8: a fault state always disables at least one phase
    a_r8_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |-> (mask_q != '0));

    // R7: ignore mode leaves everything quiet
    a_r7_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && mode == RESP_IGNORE) |=> (state_q == ST_RUN && !report_q));

    // R10: fault state entered only from an event in normal operation
    a_r10_entry_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !hit) |=> (state_q == ST_RUN));

endmodule

// File: rtl/ocp_response_ctrl.sv
module ocp_response_ctrl #(
    parameter int NPH       = 3,
    parameter int CLK_HZ    = 50_000_000,
    parameter bit SHORT_SIM = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_wr_en,
    input  logic [10:0]    cfg_wdata,
    output logic [10:0]    cfg_rdata,
    input  logic [NPH-1:0] vds_oc,
    input  logic [NPH-1:0] sen_oc,
    input  logic           clr_fault,
    output logic [NPH-1:0] bridge_en,
    output logic           oc_status,
    output logic           fault_latched,
    output logic [1:0]     dt_code
);
    import ocp_pkg::*;

    localparam int LONG_CYC  = SHORT_SIM ? 40 : CLK_HZ / 250;
    localparam int SHORT_CYC = SHORT_SIM ? 8  : CLK_HZ / 20_000;
    localparam int CNT_W     = $clog2(LONG_CYC + 1);
    localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_CYC);
    localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_CYC);

    logic [CFG_W-1:0] cfg_q;
    ocp_cfg_t         cfg;
    logic [NPH-1:0]   evt;
    logic             tmr_load;
    logic             tmr_expired;
    logic [CNT_W-1:0] tmr_val;

    ocp_cfg_reg #(.W(CFG_W), .INIT(CFG_INIT)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr_en),
        .wdata (cfg_wdata),
        .q     (cfg_q)
    );

    assign cfg       = ocp_cfg_t'(cfg_q);
    assign cfg_rdata = cfg_q;
    assign dt_code   = cfg.dt_sel;
    assign tmr_val   = cfg.fast_retry ? SHORT_V : LONG_V;

    ocp_event_merge #(.NPH(NPH)) u_merge (
        .vds_oc  (vds_oc),
        .sen_oc  (sen_oc),
        .vds_thr (cfg.vds_thr),
        .evt     (evt)
    );

    ocp_retry_timer #(.CW(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    ocp_fault_fsm #(.NPH(NPH)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt           (evt),
        .mode          (cfg.mode),
        .per_phase     (cfg.per_phase),
        .clr_fault     (clr_fault),
        .tmr_expired   (tmr_expired),
        .tmr_load      (tmr_load),
        .bridge_en     (bridge_en),
        .oc_status     (oc_status),
        .fault_latched (fault_latched)
    );

endmodule

// File: tb/ocp_response_ctrl_tb.sv
`timescale 1ns/1ps
module ocp_response_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [10:0] cfg_wdata = '0;
    logic [10:0] cfg_rdata;
    logic [2:0]  vds_oc = '0;
    logic [2:0]  sen_oc = '0;
    logic        clr_fault = 1'b0;
    logic [2:0]  bridge_en;
    logic        oc_status;
    logic        fault_latched;
    logic [1:0]  dt_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    ocp_response_ctrl #(.NPH(3), .CLK_HZ(50_000_000), .SHORT_SIM(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .vds_oc(vds_oc), .sen_oc(sen_oc),
        .clr_fault(clr_fault), .bridge_en(bridge_en), .oc_status(oc_status),
        .fault_latched(fault_latched), .dt_code(dt_code)
    );

    // {cfg, vds, sen, exp_en, exp_status, exp_latched}
    localparam logic [21:0] VEC [12] = '{
        {11'h505, 3'b001, 3'b000, 3'b000, 1'b1, 1'b1},
        {11'h525, 3'b000, 3'b010, 3'b101, 1'b1, 1'b1},
        {11'h545, 3'b000, 3'b100, 3'b000, 1'b1, 1'b0},
        {11'h565, 3'b100, 3'b000, 3'b011, 1'b1, 1'b0},
        {11'h585, 3'b011, 3'b000, 3'b111, 1'b1, 1'b0},
        {11'h5A5, 3'b000, 3'b001, 3'b111, 1'b1, 1'b0},
        {11'h5C5, 3'b111, 3'b000, 3'b111, 1'b0, 1'b0},
        {11'h5E5, 3'b000, 3'b010, 3'b111, 1'b0, 1'b0},
        {11'h567, 3'b010, 3'b000, 3'b111, 1'b0, 1'b0},
        {11'h567, 3'b000, 3'b010, 3'b101, 1'b1, 1'b0},
        {11'h525, 3'b101, 3'b000, 3'b010, 1'b1, 1'b1},
        {11'h55D, 3'b000, 3'b001, 3'b000, 1'b1, 1'b0}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [10:0] v);
        cfg_wr_en = 1'b1;
        cfg_wdata = v;
        tick();
        cfg_wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state, R11 dead-time output
        chk("R1 cfg reset", cfg_rdata, 11'h145);
        chk("R1 enables", bridge_en, 3'b111);
        chk("R1 status", oc_status, 1'b0);
        chk("R1 latched", fault_latched, 1'b0);
        chk("R11 dt reset", dt_code, 2'b01);

        // R2 readback including spare bits
        wr_cfg(11'h7FF);
        chk("R2 readback ones", cfg_rdata, 11'h7FF);
        wr_cfg(11'h2AA);
        chk("R2 readback pattern", cfg_rdata, 11'h2AA);
        wr_cfg(11'h345);
        chk("R11 dt follows", dt_code, 2'b11);

        // Table: R3 R4 R6 R7 R8 R9 and R2 spare bits
        for (int i = 0; i < 12; i++) begin
            wr_cfg(VEC[i][21:11]);
            vds_oc = VEC[i][10:8];
            sen_oc = VEC[i][7:5];
            tick();
            vds_oc = '0;
            sen_oc = '0;
            chk($sformatf("R8 row%0d enables", i), bridge_en, VEC[i][4:2]);
            chk($sformatf("R6 row%0d status", i), oc_status, VEC[i][1]);
            chk($sformatf("R3 row%0d latched", i), fault_latched, VEC[i][0]);
            clr_fault = 1'b1;
            tick();
            clr_fault = 1'b0;
            repeat (12) tick();
            chk($sformatf("R4 row%0d recovered", i), bridge_en, 3'b111);
            chk($sformatf("R7 row%0d status idle", i), oc_status, 1'b0);
        end

        // R4 long retry: 40 cycles
        wr_cfg(11'h145);
        sen_oc = 3'b001;
        tick();
        sen_oc = '0;
        for (int k = 1; k < 40; k++) tick();
        chk("R4 long last off", bridge_en, 3'b000);
        tick();
        chk("R4 long reenable", bridge_en, 3'b111);

        // R4 short retry: 8 cycles
        wr_cfg(11'h545);
        vds_oc = 3'b010;
        tick();
        vds_oc = '0;
        for (int k = 1; k < 8; k++) tick();
        chk("R4 short last off", bridge_en, 3'b000);
        tick();
        chk("R4 short reenable", bridge_en, 3'b111);

        // R5 new event during retry restarts the window and widens mask
        wr_cfg(11'h565);
        sen_oc = 3'b001;
        tick();
        sen_oc = '0;
        repeat (3) tick();
        vds_oc = 3'b100;
        tick();
        vds_oc = '0;
        chk("R5 widened mask", bridge_en, 3'b010);
        for (int k = 1; k < 8; k++) tick();
        chk("R5 restart still off", bridge_en, 3'b010);
        tick();
        chk("R5 restart reenable", bridge_en, 3'b111);

        // R3 clear ignored while a flag is held
        wr_cfg(11'h505);
        sen_oc = 3'b001;
        tick();
        clr_fault = 1'b1;
        tick();
        clr_fault = 1'b0;
        chk("R3 clear blocked", fault_latched, 1'b1);
        sen_oc = '0;
        repeat (50) tick();
        chk("R3 holds without clear", bridge_en, 3'b000);

        // R10 mode rewrite during a held fault
        wr_cfg(11'h585);
        repeat (20) tick();
        chk("R10 still latched", fault_latched, 1'b1);
        clr_fault = 1'b1;
        tick();
        clr_fault = 1'b0;
        chk("R3 clean clear", bridge_en, 3'b111);
        chk("R3 clear drops latch", fault_latched, 1'b0);
        vds_oc = 3'b001;
        tick();
        vds_oc = '0;
        chk("R10 new mode report", oc_status, 1'b1);
        chk("R10 new mode no shutdown", bridge_en, 3'b111);

        finish_run();
    end

endmodule